// File: doc/BRIEF.md
# Serial-Loaded Playback Configuration Register

This block holds the playback configuration of a multichannel audio converter. A host writes 16-bit control words over a three-wire serial port: a shift clock, a data line and a latch strobe. While the strobe is low, data bits are shifted in most significant bit first on each rising shift clock edge. A rising strobe edge ends the word and hands it to the decoder.

The upper four bits of a word carry a register address. When the address is zero, the decoder stores four configuration fields and drives them out as registered buses. The fields are de-emphasis curve, serial audio format, sample word width and interpolation ratio. Words carrying any other address belong to other registers and leave this one unchanged.

The power-down bit works differently from the other fields. It is first held in a staging register. It reaches the `pwr_down` output only at the next strobe rising edge. A host therefore writes the power-down command twice. The three port signals are sampled through synchronizers into the system clock domain.

Top module: `ctrl_word_reg`

## Requirements
- R1: After reset, every configuration output is zero, `pwr_down` is 0 and `cfg_err` is 0.
- R2: Bits are shifted MSB first on each rising `ser_clk` edge while `ser_latch` is low. The word taken at a `ser_latch` rising edge is the last 16 bits shifted, so any earlier bits are discarded.
- R3: A word whose bits 15:12 equal 0000 updates the outputs after the strobe rise. `demph_sel` takes bits 9:8 (00 off, 01 44.1 kHz, 10 32 kHz, 11 48 kHz). `fmt_sel` takes bits 7:5 (000 I2S, 001 right-justified, 010 DSP, 011 left-justified, 100 packed 256, 101 packed 128, 110 aux, 111 reserved). `width_sel` takes bits 4:3 (00 24-bit, 01 20-bit, 10 16-bit, 11 reserved). `interp_sel` takes bits 1:0 (00 8x, 01 2x, 10 4x, 11 reserved).
- R4: A word with any nonzero value in bits 15:12 leaves the four fields, `cfg_err` and the staged power-down value unchanged.
- R5: Bits 11:10 of a word have no effect on any output.
- R6: On every strobe rising edge, with any address, `pwr_down` takes the staged value. After that, an address-0000 word reloads the staging register from its bit 2 (1 = powered down). A single write of bit 2 therefore leaves `pwr_down` unchanged, and a second write applies it.
- R7: A reserved code (`fmt_sel` 111, `width_sel` 11 or `interp_sel` 11) is stored as written and raises `cfg_err`. An address-0000 word with no reserved code clears `cfg_err`.
- R8: Outputs change only in the cycles that follow a detected strobe rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Latch strobe, low while shifting |
| demph_sel | output | 2 | De-emphasis curve select |
| fmt_sel | output | 3 | Serial audio format select |
| width_sel | output | 2 | Sample word width select |
| interp_sel | output | 2 | Interpolation ratio select |
| pwr_down | output | 1 | Active power-down state |
| cfg_err | output | 1 | A stored field holds a reserved code |

## Verification
The main test pattern writes one word twice. The first write shows the fields updating while power-down stays put. The second write shows the deferred power-down being applied.

Words addressed to other registers are interleaved with these writes. This checks that they leave the fields alone while still committing the staged power-down bit. A word with both reserved bits and reserved codes set, followed by a clean word, separates the ignored bits from the flagged codes. A 20-bit burst checks that only the final 16 shifted bits count.

// File: rtl/cw_pkg.sv
package cw_pkg;
    typedef struct packed {
        logic [1:0] demph;
        logic [2:0] fmt;
        logic [1:0] width;
        logic [1:0] interp;
    } cw_cfg_t;

    localparam cw_cfg_t CFG_RESET = '0;

    function automatic logic cfg_reserved(cw_cfg_t c);
        return (c.fmt == 3'b111) || (c.width == 2'b11) || (c.interp == 2'b11);
    endfunction
endpackage

// File: rtl/cw_serial_rx.sv
module cw_serial_rx #(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_latch,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sclk_s;
        logic [SYNC_STAGES-1:0] data_s;
        logic [SYNC_STAGES-1:0] latch_s;
        logic                   sclk_prev;
        logic                   latch_prev;
        logic [WORD_W-1:0]      shreg;
        logic [WORD_W-1:0]      word;
        logic                   valid;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   sclk_rise, latch_rise;

    always_comb begin
        st_d         = st_q;
        st_d.sclk_s  = {st_q.sclk_s[SYNC_STAGES-2:0], ser_clk};
        st_d.data_s  = {st_q.data_s[SYNC_STAGES-2:0], ser_data};
        st_d.latch_s = {st_q.latch_s[SYNC_STAGES-2:0], ser_latch};
        st_d.sclk_prev  = st_q.sclk_s[LAST];
        st_d.latch_prev = st_q.latch_s[LAST];
        sclk_rise  = st_q.sclk_s[LAST] & ~st_q.sclk_prev;
        latch_rise = st_q.latch_s[LAST] & ~st_q.latch_prev;
        st_d.valid = latch_rise;
        if (sclk_rise && !st_q.latch_s[LAST])
            st_d.shreg = {st_q.shreg[WORD_W-2:0], st_q.data_s[LAST]};
        if (latch_rise)
            st_d.word = st_q.shreg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.latch_s    <= '1;
            st_q.latch_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_valid = st_q.valid;
    assign word       = st_q.word;

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R2
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> $stable(word) || word_valid);
endmodule

// File: rtl/cw_decode.sv
module cw_decode
    import cw_pkg::*;
#(
    parameter int             WORD_W  = 16,
    parameter int             ADDR_W  = 4,
    parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    output cw_cfg_t           cfg,
    output logic              pwr_down,
    output logic              cfg_err
);
    localparam int ADDR_LSB = WORD_W - ADDR_W;
    localparam int PD_BIT   = 2;

    typedef struct packed {
        cw_cfg_t cfg;
        logic    pd_stage;
        logic    pd_active;
        logic    err;
    } dec_st_t;

    dec_st_t st_d, st_q;
    cw_cfg_t incoming;
    logic    hit;

    always_comb begin
        st_d     = st_q;
        hit      = word[WORD_W-1:ADDR_LSB] == MY_ADDR;
        incoming = '{demph: word[9:8], fmt: word[7:5], width: word[4:3], interp: word[1:0]};
        if (word_valid) begin
            st_d.pd_active = st_q.pd_stage;
            if (hit) begin
                st_d.cfg      = incoming;
                st_d.pd_stage = word[PD_BIT];
                st_d.err      = cfg_reserved(incoming);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cfg: CFG_RESET, pd_stage: 1'b0, pd_active: 1'b0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg      = st_q.cfg;
    assign pwr_down = st_q.pd_active;
    assign cfg_err  = st_q.err;

    // R8
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> $stable(cfg) && $stable(pwr_down) && $stable(cfg_err));

    // R4
    foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !hit) |=> $stable(cfg) && $stable(cfg_err) && $stable(st_q.pd_stage));

    // R6
    pd_deferred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> pwr_down == $past(st_q.pd_stage));

    // R7
    err_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err == ((cfg.fmt == 3'b111) || (cfg.width == 2'b11) || (cfg.interp == 2'b11)));
endmodule

// File: rtl/ctrl_word_reg.sv
module ctrl_word_reg
    import cw_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_clk,
    input  logic       ser_data,
    input  logic       ser_latch,
    output logic [1:0] demph_sel,
    output logic [2:0] fmt_sel,
    output logic [1:0] width_sel,
    output logic [1:0] interp_sel,
    output logic       pwr_down,
    output logic       cfg_err
);
    logic              word_valid;
    logic [WORD_W-1:0] word;
    cw_cfg_t           cfg;

    cw_serial_rx #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .ser_latch  (ser_latch),
        .word_valid (word_valid),
        .word       (word)
    );

    cw_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .MY_ADDR('0)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word       (word),
        .cfg        (cfg),
        .pwr_down   (pwr_down),
        .cfg_err    (cfg_err)
    );

    assign demph_sel  = cfg.demph;
    assign fmt_sel    = cfg.fmt;
    assign width_sel  = cfg.width;
    assign interp_sel = cfg.interp;
endmodule

// File: tb/tb_ctrl_word_reg.sv
module tb_ctrl_word_reg;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_latch = 1'b1;
    logic [1:0] demph_sel, width_sel, interp_sel;
    logic [2:0] fmt_sel;
    logic pwr_down, cfg_err;

    always #2.5 clk = ~clk;

    ctrl_word_reg dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch(ser_latch), .demph_sel(demph_sel), .fmt_sel(fmt_sel),
        .width_sel(width_sel), .interp_sel(interp_sel), .pwr_down(pwr_down),
        .cfg_err(cfg_err)
    );

    typedef struct {
        logic [1:0] demph; logic [2:0] fmt; logic [1:0] width; logic [1:0] interp;
        logic pd; logic err; string req;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0, n_bad = 0;
    logic [1:0] m_demph = 0, m_width = 0, m_interp = 0;
    logic [2:0] m_fmt = 0;
    logic m_stage = 0, m_pd = 0, m_err = 0;
    event sent;
    bit done = 0;

    task automatic check(string req, string what, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic shift_bits(logic [31:0] w, int n, string req);
        exp_t e;
        logic [15:0] wd = w[15:0];
        ser_latch = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = w[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (3) @(negedge clk);
        ser_latch = 1'b1;
        m_pd = m_stage;
        if (wd[15:12] == 4'b0000) begin
            m_demph = wd[9:8]; m_fmt = wd[7:5]; m_width = wd[4:3]; m_interp = wd[1:0];
            m_stage = wd[2];
            m_err = (m_fmt == 3'b111) || (m_width == 2'b11) || (m_interp == 2'b11);
        end
        e = '{demph: m_demph, fmt: m_fmt, width: m_width, interp: m_interp,
              pd: m_pd, err: m_err, req: req};
        exp_q.push_back(e);
        -> sent;
        repeat (14) @(negedge clk);
    endtask

    // monitor: compares once the strobe edge has crossed sync, rx and decode stages
    initial begin
        forever begin
            exp_t e;
            @(sent);
            repeat (9) @(negedge clk);
            e = exp_q.pop_front();
            check(e.req, "demph_sel", demph_sel, e.demph);
            check(e.req, "fmt_sel", fmt_sel, e.fmt);
            check(e.req, "width_sel", width_sel, e.width);
            check(e.req, "interp_sel", interp_sel, e.interp);
            check(e.req, "pwr_down", pwr_down, e.pd);
            check(e.req, "cfg_err", cfg_err, e.err);
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1", "demph_sel", demph_sel, 0);
        check("R1", "fmt_sel", fmt_sel, 0);
        check("R1", "width_sel", width_sel, 0);
        check("R1", "interp_sel", interp_sel, 0);
        check("R1", "pwr_down", pwr_down, 0);
        check("R1", "cfg_err", cfg_err, 0);
        shift_bits(32'h016E, 16, "R3");     // fields load, power-down only staged
        shift_bits(32'h016E, 16, "R6");     // second write applies power-down
        shift_bits(32'h3FFF, 16, "R4");     // foreign address ignored
        shift_bits(32'h02F1, 16, "R7");     // reserved format flagged, stage cleared
        shift_bits(32'h5000, 16, "R6");     // foreign address still commits stage
        shift_bits(32'h0F1B, 16, "R5");     // bits 11:10 set, width/interp reserved
        shift_bits(32'hF0300, 20, "R2");    // leading 4 bits discarded
        shift_bits(32'h0004, 16, "R6");
        shift_bits(32'h0004, 16, "R6");
        repeat (12) @(negedge clk);
        check("R2", "queue drained", exp_q.size(), 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(negedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule